// File: doc/BRIEF.md
# DMA Buffer Boundary Pause Controller

This block tracks the system byte address of a single-address DMA transfer. Each byte-transfer strobe moves the address up by one. A 3-bit boundary code selects a contiguous buffer size, a power of two from 4 KB to 512 KB. When the address carries out of the top bit of the selected in-buffer offset, the block pauses the transfer and raises a one-cycle DMA interrupt request. Software then supplies a fresh buffer address, and that write releases the pause.

The boundary code and the DMA-enable level are captured when a transfer starts and held until it completes. No DMA interrupt is raised in the cycle that a transfer completes or at any time after it. The block also holds the transfer block size value. Writes to that value are refused while a transfer is in progress.

Top module: `sdma_bound_ctl`

## Requirements
- R1: After reset, cur_addr, blk_size, paused, busy, dma_irq, dma_irq_sts and cmpl_irq are all zero.
- R2: A byte_stb in a cycle where busy=1, paused=0 and addr_wr=0 makes cur_addr one greater on the next cycle.
- R3: With boundary code n latched and DMA enabled, a counted strobe while cur_addr bits [11+n:0] are all ones sets paused and pulses dma_irq for exactly one cycle on the next cycle. cur_addr moves to the crossed value. A 4 KB code (0) therefore pauses entering 0x1000, and code 7 pauses entering 0x80000.
- R4: While paused, byte_stb leaves cur_addr unchanged.
- R5: An addr_wr loads addr_wdata into cur_addr and clears paused on the next cycle. Later strobes count up from the loaded value.
- R6: A transfer started with dma_en=0 never pauses and never raises dma_irq on a boundary crossing.
- R7: bnd_code and dma_en are sampled only on the xfer_start cycle. Later changes to them have no effect on the running transfer.
- R8: xfer_done ends the transfer. The cycle after it, cmpl_irq pulses and busy is 0. A crossing strobe in the xfer_done cycle produces neither a pause nor dma_irq, and dma_irq never rises while busy is 0.
- R9: A blk_wr while busy=0 stores the 12-bit blk_wdata into blk_size (0 meaning no data, up to 0x800). A blk_wr while busy=1 is ignored.
- R10: dma_irq_sts is set the cycle after a dma_irq pulse. It is cleared by irq_clr=1, unless a dma_irq pulse arrives in the same cycle, in which case it stays set.
- R11: byte_stb while busy=0 leaves cur_addr unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | Transfer start event; ignored while busy |
| xfer_done | input | 1 | Transfer complete event |
| byte_stb | input | 1 | One data byte moved this cycle |
| bnd_code | input | 3 | Buffer boundary code, size = 4 KB << code |
| dma_en | input | 1 | Single-address DMA enable level |
| addr_wr | input | 1 | System address register write |
| addr_wdata | input | 32 | System address write data |
| blk_wr | input | 1 | Block size register write |
| blk_wdata | input | 12 | Block size write data in bytes |
| irq_clr | input | 1 | Write-1 clear of the DMA interrupt status |
| cur_addr | output | 32 | Current system byte address |
| paused | output | 1 | Transfer halted at a buffer boundary |
| busy | output | 1 | Transfer in progress |
| dma_irq | output | 1 | One-cycle DMA interrupt pulse |
| dma_irq_sts | output | 1 | Sticky DMA interrupt status |
| cmpl_irq | output | 1 | One-cycle transfer complete pulse |
| blk_size | output | 12 | Transfer block size register |

## Verification
Addresses are walked across boundaries at the smallest, a middle and the largest code. A 4 KB carry under the 32 KB code must not pause, which separates the selected carry bit from its neighbours. The same crossing is repeated with DMA disabled, with the code and enable changed in the middle of a transfer, and with completion in the same cycle as the crossing. These runs separate the latched settings from live ones and show that completion suppresses the interrupt. Strobes sent while paused or idle, and block size writes sent while busy, must leave the visible state unchanged.

// File: rtl/sdma_bound_pkg.sv
package sdma_bound_pkg;
    parameter int ADDR_W_DEF   = 32;
    parameter int BLK_W_DEF    = 12;
    parameter int CODE_W_DEF   = 3;
    parameter int BASE_BIT_DEF = 11;

    typedef enum logic {
        XF_IDLE = 1'b0,
        XF_RUN  = 1'b1
    } xfer_st_e;
endpackage

// File: rtl/sdma_bnd_detect.sv
module sdma_bnd_detect #(
    parameter int ADDR_W   = sdma_bound_pkg::ADDR_W_DEF,
    parameter int CODE_W   = sdma_bound_pkg::CODE_W_DEF,
    parameter int BASE_BIT = sdma_bound_pkg::BASE_BIT_DEF
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              hit_o
);
    localparam int NSEL = 1 << CODE_W;

    logic [NSEL-1:0] ones;

    // One all-ones detector per selectable carry bit
    for (genvar g = 0; g < NSEL; g++) begin : g_sel
        assign ones[g] = &addr_i[BASE_BIT+g:0];
    end

    assign hit_o = ones[code_i];
endmodule

// File: rtl/sdma_addr_trk.sv
module sdma_addr_trk #(
    parameter int ADDR_W   = sdma_bound_pkg::ADDR_W_DEF,
    parameter int CODE_W   = sdma_bound_pkg::CODE_W_DEF,
    parameter int BASE_BIT = sdma_bound_pkg::BASE_BIT_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              done_i,
    input  logic              stb_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              en_i,
    input  logic              addr_wr_i,
    input  logic [ADDR_W-1:0] addr_wdata_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              paused_o,
    output logic              busy_o,
    output logic              dma_irq_o,
    output logic              cmpl_irq_o
);
    import sdma_bound_pkg::*;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        xfer_st_e          st;
        logic              paused;
        logic              en;
        logic [CODE_W-1:0] code;
        logic              dma_irq;
        logic              cmpl_irq;
    } trk_t;

    trk_t q, d;
    logic hit;

    sdma_bnd_detect #(
        .ADDR_W  (ADDR_W),
        .CODE_W  (CODE_W),
        .BASE_BIT(BASE_BIT)
    ) i_detect (
        .addr_i(q.addr),
        .code_i(q.code),
        .hit_o (hit)
    );

    always_comb begin
        d          = q;
        d.dma_irq  = 1'b0;
        d.cmpl_irq = 1'b0;
        if (q.st == XF_IDLE) begin
            if (start_i) begin
                d.st     = XF_RUN;
                d.code   = code_i;
                d.en     = en_i;
                d.paused = 1'b0;
            end
        end else begin
            if (stb_i && !q.paused && !addr_wr_i) begin
                d.addr = q.addr + ADDR_W'(1);
                if (q.en && hit && !done_i) begin
                    d.paused  = 1'b1;
                    d.dma_irq = 1'b1;
                end
            end
            if (done_i) begin
                d.st       = XF_IDLE;
                d.paused   = 1'b0;
                d.cmpl_irq = 1'b1;
            end
        end
        if (addr_wr_i) begin
            d.addr   = addr_wdata_i;
            d.paused = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign addr_o     = q.addr;
    assign paused_o   = q.paused;
    assign busy_o     = (q.st == XF_RUN);
    assign dma_irq_o  = q.dma_irq;
    assign cmpl_irq_o = q.cmpl_irq;
endmodule

// File: rtl/sdma_blksz_reg.sv
module sdma_blksz_reg #(
    parameter int BLK_W = sdma_bound_pkg::BLK_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [BLK_W-1:0] wdata_i,
    input  logic             busy_i,
    output logic [BLK_W-1:0] size_o
);
    logic [BLK_W-1:0] size_d, size_q;

    always_comb begin
        size_d = size_q;
        if (wr_i && !busy_i) begin
            size_d = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= '0;
        end else begin
            size_q <= size_d;
        end
    end

    assign size_o = size_q;
endmodule

// File: rtl/sdma_irq_stat.sv
module sdma_irq_stat (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic sts_o
);
    logic sts_d, sts_q;

    always_comb begin
        sts_d = sts_q;
        if (set_i) begin
            sts_d = 1'b1;
        end else if (clr_i) begin
            sts_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= 1'b0;
        end else begin
            sts_q <= sts_d;
        end
    end

    assign sts_o = sts_q;
endmodule

// File: rtl/sdma_bound_ctl.sv
module sdma_bound_ctl #(
    parameter int ADDR_W   = sdma_bound_pkg::ADDR_W_DEF,
    parameter int BLK_W    = sdma_bound_pkg::BLK_W_DEF,
    parameter int CODE_W   = sdma_bound_pkg::CODE_W_DEF,
    parameter int BASE_BIT = sdma_bound_pkg::BASE_BIT_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_start,
    input  logic              xfer_done,
    input  logic              byte_stb,
    input  logic [CODE_W-1:0] bnd_code,
    input  logic              dma_en,
    input  logic              addr_wr,
    input  logic [ADDR_W-1:0] addr_wdata,
    input  logic              blk_wr,
    input  logic [BLK_W-1:0]  blk_wdata,
    input  logic              irq_clr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              paused,
    output logic              busy,
    output logic              dma_irq,
    output logic              dma_irq_sts,
    output logic              cmpl_irq,
    output logic [BLK_W-1:0]  blk_size
);
    sdma_addr_trk #(
        .ADDR_W  (ADDR_W),
        .CODE_W  (CODE_W),
        .BASE_BIT(BASE_BIT)
    ) i_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (xfer_start),
        .done_i      (xfer_done),
        .stb_i       (byte_stb),
        .code_i      (bnd_code),
        .en_i        (dma_en),
        .addr_wr_i   (addr_wr),
        .addr_wdata_i(addr_wdata),
        .addr_o      (cur_addr),
        .paused_o    (paused),
        .busy_o      (busy),
        .dma_irq_o   (dma_irq),
        .cmpl_irq_o  (cmpl_irq)
    );

    sdma_blksz_reg #(
        .BLK_W(BLK_W)
    ) i_blksz (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (blk_wr),
        .wdata_i(blk_wdata),
        .busy_i (busy),
        .size_o (blk_size)
    );

    sdma_irq_stat i_irq_stat (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(dma_irq),
        .clr_i(irq_clr),
        .sts_o(dma_irq_sts)
    );
endmodule

// File: rtl/sdma_bound_chk.sv
module sdma_bound_chk #(
    parameter int ADDR_W = sdma_bound_pkg::ADDR_W_DEF,
    parameter int BLK_W  = sdma_bound_pkg::BLK_W_DEF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              byte_stb,
    input logic              addr_wr,
    input logic [ADDR_W-1:0] addr_wdata,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              paused,
    input logic              busy,
    input logic              dma_irq,
    input logic              dma_irq_sts,
    input logic              cmpl_irq,
    input logic [BLK_W-1:0]  blk_size
);
    // R2: counted strobe advances the address by one
    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !paused && byte_stb && !addr_wr |=> cur_addr == $past(cur_addr) + ADDR_W'(1));

    // R3: the boundary interrupt lasts a single cycle
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dma_irq |=> !dma_irq);

    // R4: a paused transfer holds its address
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        paused && !addr_wr |=> $stable(cur_addr));

    // R5: address write loads and unpauses
    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        addr_wr |=> !paused && cur_addr == $past(addr_wdata));

    // R8: no DMA interrupt outside a transfer or alongside completion
    a_r8_no_late_irq: assert property (@(posedge clk) disable iff (!rst_n)
        dma_irq |-> busy && !cmpl_irq);

    // R9: block size frozen while busy
    a_r9_blk_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(blk_size));

    // R10: status latches the pulse
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        dma_irq |=> dma_irq_sts);
endmodule

bind sdma_bound_ctl sdma_bound_chk #(
    .ADDR_W(ADDR_W),
    .BLK_W (BLK_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_stb   (byte_stb),
    .addr_wr    (addr_wr),
    .addr_wdata (addr_wdata),
    .cur_addr   (cur_addr),
    .paused     (paused),
    .busy       (busy),
    .dma_irq    (dma_irq),
    .dma_irq_sts(dma_irq_sts),
    .cmpl_irq   (cmpl_irq),
    .blk_size   (blk_size)
);

// File: tb/test_sdma_bound_ctl.sv
module test_sdma_bound_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_start = 1'b0;
    logic        xfer_done = 1'b0;
    logic        byte_stb = 1'b0;
    logic [2:0]  bnd_code = 3'd0;
    logic        dma_en = 1'b0;
    logic        addr_wr = 1'b0;
    logic [31:0] addr_wdata = 32'd0;
    logic        blk_wr = 1'b0;
    logic [11:0] blk_wdata = 12'd0;
    logic        irq_clr = 1'b0;
    logic [31:0] cur_addr;
    logic        paused, busy, dma_irq, dma_irq_sts, cmpl_irq;
    logic [11:0] blk_size;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sdma_bound_ctl i_sdma_bound_ctl (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_done(xfer_done),
        .byte_stb(byte_stb), .bnd_code(bnd_code), .dma_en(dma_en),
        .addr_wr(addr_wr), .addr_wdata(addr_wdata), .blk_wr(blk_wr),
        .blk_wdata(blk_wdata), .irq_clr(irq_clr), .cur_addr(cur_addr),
        .paused(paused), .busy(busy), .dma_irq(dma_irq),
        .dma_irq_sts(dma_irq_sts), .cmpl_irq(cmpl_irq), .blk_size(blk_size)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Advance one edge; inputs set before it take effect, outputs then settled
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        xfer_start = 0; xfer_done = 0; byte_stb = 0; addr_wr = 0;
        blk_wr = 0; irq_clr = 0;
    endtask

    task automatic wr_addr(input logic [31:0] a);
        addr_wr = 1; addr_wdata = a; step(); addr_wr = 0;
    endtask

    task automatic start(input logic [2:0] code, input logic en);
        xfer_start = 1; bnd_code = code; dma_en = en; step(); xfer_start = 0;
    endtask

    task automatic finish_xfer();
        xfer_done = 1; step(); xfer_done = 0;
    endtask

    task automatic stb1();
        byte_stb = 1; step(); byte_stb = 0;
    endtask

    task automatic t_reset();
        chk("R1 addr", cur_addr, 0);
        chk("R1 blk", {20'd0, blk_size}, 0);
        chk("R1 flags", {26'd0, paused, busy, dma_irq, dma_irq_sts, cmpl_irq}, 0);
    endtask

    task automatic t_blk();
        blk_wr = 1; blk_wdata = 12'h800; step(); blk_wr = 0;
        chk("R9 idle write 0x800", {20'd0, blk_size}, 32'h800);
        start(3'd0, 1'b1);
        blk_wr = 1; blk_wdata = 12'h007; step(); blk_wr = 0;
        chk("R9 busy write ignored", {20'd0, blk_size}, 32'h800);
        finish_xfer();
        blk_wr = 1; blk_wdata = 12'h200; step(); blk_wr = 0;
        chk("R9 idle write 0x200", {20'd0, blk_size}, 32'h200);
    endtask

    task automatic t_advance();
        wr_addr(32'h100);
        stb1();
        chk("R11 idle strobe ignored", cur_addr, 32'h100);
        start(3'd0, 1'b1);
        byte_stb = 1; step(); step(); step(); byte_stb = 0;
        chk("R2 three strobes", cur_addr, 32'h103);
        finish_xfer();
        chk("R8 cmpl pulse", {30'd0, cmpl_irq, busy}, 32'h2);
    endtask

    task automatic t_bound4k();
        wr_addr(32'h1FFE);
        start(3'd0, 1'b1);
        stb1();
        chk("R3 no pause before carry", {cur_addr[30:0], paused}, {31'h1FFF, 1'b0});
        stb1();
        chk("R3 crossing addr", cur_addr, 32'h2000);
        chk("R3 paused+irq", {30'd0, paused, dma_irq}, 32'h3);
        step();
        chk("R3 irq one cycle", {31'd0, dma_irq}, 0);
        chk("R10 status set", {31'd0, dma_irq_sts}, 1);
        byte_stb = 1; step(); step(); byte_stb = 0;
        chk("R4 paused holds", cur_addr, 32'h2000);
        wr_addr(32'h0004_0000);
        chk("R5 reload addr", cur_addr, 32'h0004_0000);
        chk("R5 unpaused", {31'd0, paused}, 0);
        stb1();
        chk("R5 count from new", cur_addr, 32'h0004_0001);
        irq_clr = 1; step(); irq_clr = 0;
        chk("R10 w1c clears", {31'd0, dma_irq_sts}, 0);
        finish_xfer();
        chk("R8 cmpl after", {30'd0, cmpl_irq, busy}, 32'h2);
    endtask

    task automatic t_code3();
        wr_addr(32'h0FFF);
        start(3'd3, 1'b1);
        stb1();
        chk("R3 code3 ignores 4K carry", {cur_addr[30:0], paused}, {31'h1000, 1'b0});
        wr_addr(32'h7FFF);
        stb1();
        chk("R3 code3 32K crossing", {cur_addr[30:0], paused}, {31'h8000, 1'b1});
        finish_xfer();
    endtask

    task automatic t_code7();
        wr_addr(32'h7FFFF);
        start(3'd7, 1'b1);
        irq_clr = 1;
        stb1();
        chk("R3 code7 512K crossing", {cur_addr[30:0], dma_irq}, {31'h80000, 1'b1});
        step();
        irq_clr = 0;
        chk("R10 set beats clear", {31'd0, dma_irq_sts}, 1);
        irq_clr = 1; step(); irq_clr = 0;
        finish_xfer();
    endtask

    task automatic t_disabled();
        wr_addr(32'hFFF);
        start(3'd0, 1'b0);
        stb1();
        chk("R6 no pause when disabled", {cur_addr[29:0], paused, dma_irq}, {30'h1000, 2'b00});
        step();
        chk("R6 status untouched", {31'd0, dma_irq_sts}, 0);
        finish_xfer();
    endtask

    task automatic t_latched();
        wr_addr(32'hFFF);
        start(3'd1, 1'b1);
        bnd_code = 3'd0; dma_en = 1'b0;
        stb1();
        chk("R7 live code ignored", {cur_addr[30:0], paused}, {31'h1000, 1'b0});
        wr_addr(32'h1FFF);
        stb1();
        chk("R7 latched enable/code used", {cur_addr[30:0], paused}, {31'h2000, 1'b1});
        finish_xfer();
        irq_clr = 1; step(); irq_clr = 0;
    endtask

    task automatic t_done_cross();
        wr_addr(32'hFFF);
        start(3'd0, 1'b1);
        byte_stb = 1; xfer_done = 1; step(); byte_stb = 0; xfer_done = 0;
        chk("R8 crossing with done addr", cur_addr, 32'h1000);
        chk("R8 no irq/pause at done", {29'd0, dma_irq, paused, cmpl_irq}, 32'h1);
        step();
        chk("R8 no irq after done", {30'd0, dma_irq, busy}, 0);
        stb1();
        chk("R11 strobe after done ignored", cur_addr, 32'h1000);
    endtask

    initial begin
        idle_inputs();
        step();
        step();
        t_reset();
        rst_n = 1;
        step();
        t_blk();
        t_advance();
        t_bound4k();
        t_code3();
        t_code7();
        t_disabled();
        t_latched();
        t_done_cross();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(4 * 20000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule